// File: doc/BRIEF.md
# Converter start sequencer with automatic power-down

This block holds the digital timing and control for a sampling converter that has one active-high start input. A rising edge on the start input wakes the converter and fires a fixed-length internal warm-up pulse. The warm-up pulse is ORed with the start input to form a gated start. The conversion begins once the gated start is low, so it follows whichever of the two signals drops later. While the conversion runs, `busy_o` is high. When it ends, the value on `data_i` is captured into an 8-bit result register. The analog sampling is not modelled here: `data_i` stands in for the converter's output.

The level of the start input when the conversion ends picks the next power state. If it is high, the converter stays awake and the next falling edge of the start input begins another conversion at once, with no warm-up pulse. If it is low, the converter powers down and waits for a new rising edge. The result register keeps its value and stays readable while powered down. The start input is asynchronous and passes through a synchronizer. Every timing below is counted in system-clock cycles, from the clock edge that launches a new value on an input.

Top module: `adc_start_seq`

## Requirements
- R1: Reset (rst_ni low) leaves busy_o low, pwr_up_o low (powered down) and data_o at zero.
- R2: A rising edge on start_i is seen after a two-flop synchronizer. It sets pwr_up_o, which is first high 3 cycles after the edge. It also starts an internal pulse that is high for PULSE_CYCLES cycles.
- R3: A conversion starts one cycle after the gated start (synchronized start_i OR internal pulse) goes low. Take a start_i high time of H cycles. busy_o is first high max(H+3, PULSE_CYCLES+4) cycles after the rising edge of start_i.
- R4: busy_o stays high for exactly CONV_CYCLES cycles for each conversion.
- R5: data_o takes the value of data_i in the cycle where busy_o falls. It keeps that value at all other times, including while powered down.
- R6: If start_i (synchronized) is high when busy_o falls, pwr_up_o stays high. The next falling edge of start_i then starts a conversion after 3 cycles, with no warm-up pulse.
- R7: If start_i is low when busy_o falls, pwr_up_o goes low in that same cycle. No further conversion starts until a new rising edge of start_i.
- R8: A rising edge of start_i that arrives while busy_o is high is ignored. It does not fire the pulse, wake the block or arm another conversion.
- R9: Whenever busy_o is high, pwr_up_o is high and the internal pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Asynchronous active-high convert-start |
| data_i | input | DATA_W | Conversion result presented by the converter |
| busy_o | output | 1 | High while a conversion runs |
| pwr_up_o | output | 1 | High when awake, low when powered down |
| data_o | output | DATA_W | Latched conversion result |

## Verification
The assertions check on every cycle that a conversion never overlaps the warm-up pulse and never runs while powered down. They also check that every conversion lasts CONV_CYCLES cycles, that the result and the power state are taken at the falling edge of busy_o, and that the pulse restarts on an accepted edge. The bench's scenarios show the exact latencies. It sweeps the start high time across the pulse length to show that the later falling edge wins. Scenarios also show the back-to-back conversions in the awake mode, the rising edge ignored during a conversion, and the absence of any conversion after power-down.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    PWR_DOWN = 1'b0,
    PWR_UP   = 1'b1
  } pwr_e;
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_pwrup_timer.sv
module adc_pwrup_timer #(
  parameter int PULSE_CYCLES = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CNT_W'(PULSE_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);

  assign pulse_o = (cnt_q != '0);

  p_pulse_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pulse_o);
  p_pulse_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> ($past(cnt_q) == CNT_W'(1)) && !$past(trig_i));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic              rise_i,
  input  logic              pulse_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              trig_o,
  output logic              busy_o,
  output logic              pwr_up_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic              armed_q;
  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  pwr_e              pwr_q;
  logic [DATA_W-1:0] res_q;
  logic              gated;
  logic              go;
  logic              done;

  // edges during a conversion are dropped
  assign trig_o = rise_i & ~busy_q;
  assign gated  = level_i | pulse_i;
  assign go     = armed_q & ~gated & ~busy_q;
  assign done   = busy_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pwr_q   <= PWR_DOWN;
      res_q   <= '0;
    end else begin
      if (trig_o) begin
        armed_q <= 1'b1;
        pwr_q   <= PWR_UP;
      end
      if (go) begin
        armed_q <= 1'b0;
        busy_q  <= 1'b1;
        cnt_q   <= CW'(CONV_CYCLES - 1);
      end else if (done) begin
        busy_q  <= 1'b0;
        res_q   <= data_i;
        armed_q <= level_i;            // still high: next fall converts, no warm-up
        pwr_q   <= level_i ? PWR_UP : PWR_DOWN;
      end else if (busy_q) begin
        cnt_q   <= cnt_q - CW'(1);
      end
    end

  assign busy_o   = busy_q;
  assign pwr_up_o = (pwr_q == PWR_UP);
  assign data_o   = res_q;

  // independent run-length monitor
  int unsigned run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     run_len_q <= 0;
    else if (busy_q) run_len_q <= run_len_q + 1;
    else             run_len_q <= 0;

  p_busy_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(run_len_q) == CONV_CYCLES - 1));
  p_start_gate_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !$past(level_i) && !$past(pulse_i));
  p_latch_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> res_q == $past(data_i));
  p_hold_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_q) |-> $stable(res_q));
  p_mode_pick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> pwr_up_o == $past(level_i));
  p_busy_awake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> pwr_up_o && !pulse_i);
  p_no_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> !armed_q);
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int CLK_MHZ      = 125,
  parameter int PULSE_CYCLES = CLK_MHZ,   // 1 us warm-up
  parameter int CONV_CYCLES  = 20,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              pwr_up_o,
  output logic [DATA_W-1:0] data_o
);
  logic lvl, rise, trig, pulse;

  adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (start_i),
    .level_o (lvl),
    .rise_o  (rise)
  );

  adc_pwrup_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .pulse_o (pulse)
  );

  adc_conv_ctrl #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (lvl),
    .rise_i   (rise),
    .pulse_i  (pulse),
    .data_i   (data_i),
    .trig_o   (trig),
    .busy_o   (busy_o),
    .pwr_up_o (pwr_up_o),
    .data_o   (data_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o);
endmodule

// File: tb/adc_start_seq_test.sv
`timescale 1ns/1ps
module adc_start_seq_test;
  localparam int P = 6;
  localparam int C = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] din = '0;
  logic          busy, pwr;
  logic [DW-1:0] dout;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  adc_start_seq #(.PULSE_CYCLES(P), .CONV_CYCLES(C), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(din),
    .busy_o(busy), .pwr_up_o(pwr), .data_o(dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // raise start, drop after hold negedges; measure wake, busy latency and width
  task automatic conv_run(input int hold, input logic [DW-1:0] d, input bit end_high,
                          output int wake, output int lat, output int width);
    start = 1'b1; din = d; wake = 0; lat = 0; width = 0;
    for (int n = 1; n < 400 && lat == 0; n++) begin
      @(negedge clk);
      if (pwr && wake == 0) wake = n;
      if (busy) lat = n;
      if (n == hold) start = 1'b0;
    end
    if (end_high) start = 1'b1;
    while (busy && width < 400) begin
      width++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wake, lat, width, exp_lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy, "R1 busy", busy, 0);
    check(!pwr, "R1 pwr", pwr, 0);
    check(dout == 0, "R1 data", dout, 0);

    // sweep start high time across the warm-up length
    for (int h = 1; h <= P + 6; h++) begin
      logic [DW-1:0] d;
      d = DW'(h * 37 + 5);
      conv_run(h, d, 1'b0, wake, lat, width);
      exp_lat = (h + 3 > P + 4) ? h + 3 : P + 4;
      check(wake == 3, "R2 wake latency", wake, 3);
      check(lat == exp_lat, "R3 busy latency", lat, exp_lat);
      check(width == C, "R4 busy width", width, C);
      check(dout == d, "R5 latched result", dout, d);
      check(!pwr, "R7 powered down", pwr, 0);
      din = ~d;
      repeat (12) @(negedge clk);
      check(!busy, "R7 no extra conversion", busy, 0);
      check(dout == d, "R5 held while down", dout, d);
    end

    // awake mode: start high again at end of conversion
    conv_run(2, 8'h5A, 1'b1, wake, lat, width);
    check(lat == P + 4, "R3 latency before awake run", lat, P + 4);
    check(pwr, "R6 stays awake", pwr, 1);
    check(dout == 8'h5A, "R5 result awake", dout, 8'h5A);
    repeat (4) @(negedge clk);
    check(!busy, "R6 no conversion while start high", busy, 0);
    check(pwr, "R6 awake idle", pwr, 1);
    start = 1'b0; din = 8'hC3; lat = 0;
    for (int n = 1; n < 50 && lat == 0; n++) begin
      @(negedge clk);
      if (busy) lat = n;
      // rising edge during conversion must be ignored
      if (n == lat) start = 1'b1;
    end
    check(lat == 3, "R6 fall-to-busy latency", lat, 3);
    @(negedge clk);
    start = 1'b0;
    width = 1;
    while (busy && width < 50) begin
      width++;
      @(negedge clk);
    end
    check(width == C, "R4 awake-run width", width, C);
    check(dout == 8'hC3, "R5 awake-run result", dout, 8'hC3);
    check(!pwr, "R8 ignored edge did not wake", pwr, 0);
    lat = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (busy || pwr) lat = n;
    end
    check(lat == 0, "R8 ignored edge armed nothing", lat, 0);

    // wake again after the ignored edge
    conv_run(P + 2, 8'h81, 1'b0, wake, lat, width);
    check(wake == 3, "R2 rewake latency", wake, 3);
    check(lat == P + 5, "R3 rewake busy latency", lat, P + 5);
    check(dout == 8'h81, "R5 rewake result", dout, 8'h81);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule